// File: doc/BRIEF.md
# Register-Driven Two-Wire Bus Master

This block is a single-transaction master for a two-wire serial bus (I2C/SMBus style). Software controls it through one 32-bit register word made of four byte fields: a data byte, an index byte, a target byte and a control byte. Software first writes the data and index bytes and selects the protocol. It then writes the target byte, and that write launches one bus transaction. The protocol is byte write, byte read or quick command.

For a byte transaction, the index byte goes out on the bus as the word address. A byte read ends with a repeated start, a single received byte, a master not-acknowledge and a stop. The received byte then replaces the data byte and the read-data-valid flag is raised. A quick command sends only the target address with its direction bit, followed by a stop. Any address or data byte that the target fails to acknowledge raises the error flag and ends the transaction at once with a stop.

Both bus lines are open-drain. The block only pulls a line low or releases it. A parameterised divider sets the bit rate. Each bit lasts four quarter periods of `QTR_DIV` system clocks each.

Top module: `twb_master`

## Requirements
- R1: Register layout and readback. Bits 7:0 are the data byte. Bits 15:8 are the index byte. Bits 23:16 are the target byte: bits 23:17 hold the 7-bit device address and bit 16 is the direction (1 = read). In the control byte, bit 24 is protocol select (1 = quick command) and is writable. Bits 25 (read-data-valid), 26 (error) and 27 (busy) are read-only status. Bits 31:28 read 0. After reset the whole word reads 0.
- R2: A write that includes the target byte (write strobe 2) while the block is idle launches a transaction. Busy reads 1 from the cycle after that write until the transaction ends, within a few quarter periods after the stop condition.
- R3: A byte write produces, in this order: start, address with write bit, acknowledge, index byte, acknowledge, data byte, acknowledge, stop. Bytes are sent MSB first.
- R4: A byte read produces, in this order: start, address with write bit, acknowledge, index byte, acknowledge, repeated start, address with read bit, acknowledge, one received byte, master not-acknowledge (SDA released), stop. After a read that completes without error, the data byte holds the received byte and read-data-valid is 1.
- R5: A quick command produces only start, address with its direction bit, acknowledge and stop. The index and data bytes are not sent, read-data-valid stays 0 and the data byte is unchanged.
- R6: When the target does not acknowledge a byte, the block sends a stop right after that acknowledge bit and sends no further byte. At the end it shows error = 1, read-data-valid = 0 and an unchanged data byte.
- R7: A write to the target byte while busy is ignored. The stored target byte is unchanged and no second transaction follows.
- R8: A launching write clears read-data-valid and error in the same cycle that busy sets.
- R9: While the block is idle, both lines are released. During bit transfers SDA changes only while SCL is low. SDA changes while SCL is high only to form a start, a repeated start or a stop.
- R10: Bytes written in the same word as the launching target byte take effect for that transaction. This covers the data and index bytes and protocol select.
- R11: Every SCL high period that starts and ends during a transaction lasts 2 * QTR_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_wstrb | input | 4 | Byte write strobes for the register word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register word readback with status |
| scl_oe | output | 1 | Pull SCL low when 1, release when 0 |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
Two functions can coincide in the same cycle. The first is the launch caused by the target-byte write, together with register updates carried in the same word: new data, new index or a new protocol-select value. The bench writes all four bytes in one word. It then decodes the bus at the pins with a behavioural target model and requires that the transaction uses the freshly written values. The second is a target-byte write that falls while a transaction is still running. That write is issued partway through a transfer, and it is judged by comparing the logged bus events against a single expected transaction and by the unchanged target byte on readback.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_START,
        SQ_ADDR1,
        SQ_INDEX,
        SQ_WDATA,
        SQ_RSTART,
        SQ_ADDR2,
        SQ_RDATA,
        SQ_STOP
    } sq_state_e;

    typedef struct packed {
        logic       quick;
        logic       rd;
        logic [6:0] dev;
        logic [7:0] index;
        logic [7:0] wdata;
    } twb_cmd_t;

    localparam int BYTE_DATA  = 0;
    localparam int BYTE_INDEX = 1;
    localparam int BYTE_TGT   = 2;
    localparam int BYTE_CTL   = 3;

endpackage

// File: rtl/twb_clkdiv.sv
module twb_clkdiv #(
    parameter int QTR_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (restart || div_q.cnt == LAST) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick = !restart && (div_q.cnt == LAST);

    generate
        if (QTR_DIV > 1) begin : g_spacing
            // R11: quarter ticks never come back to back
            a_r11_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/twb_seq.sv
module twb_seq
    import twb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     go,
    input  twb_cmd_t cmd,
    input  logic     sda_in,
    output logic     scl_low,
    output logic     sda_low,
    output logic     done,
    output logic     nack,
    output logic     rx_valid,
    output logic [7:0] rx_byte
);
    typedef struct packed {
        sq_state_e  st;
        logic [1:0] qtr;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic       nack;
        twb_cmd_t   cmd;
    } seq_t;

    seq_t seq_d, seq_q;
    logic in_byte;
    logic receiving;

    assign in_byte = (seq_q.st == SQ_ADDR1) || (seq_q.st == SQ_INDEX) ||
                     (seq_q.st == SQ_WDATA) || (seq_q.st == SQ_ADDR2) ||
                     (seq_q.st == SQ_RDATA);
    assign receiving = (seq_q.st == SQ_RDATA);

    always_comb begin
        seq_d = seq_q;
        done  = 1'b0;
        if (go && seq_q.st == SQ_IDLE) begin
            seq_d.st   = SQ_START;
            seq_d.qtr  = 2'd0;
            seq_d.bitn = 4'd0;
            seq_d.nack = 1'b0;
            seq_d.cmd  = cmd;
        end else if (tick && seq_q.st != SQ_IDLE) begin
            seq_d.qtr = seq_q.qtr + 2'd1;
            if (in_byte && seq_q.qtr == 2'd1) begin
                if (seq_q.bitn != 4'd8) begin
                    if (receiving) seq_d.sh = {seq_q.sh[6:0], sda_in};
                end else if (!receiving && sda_in) begin
                    seq_d.nack = 1'b1;
                end
            end
            if (seq_q.qtr == 2'd3) begin
                case (seq_q.st)
                    SQ_START: begin
                        seq_d.st   = SQ_ADDR1;
                        seq_d.bitn = 4'd0;
                        seq_d.sh   = {seq_q.cmd.dev, seq_q.cmd.quick & seq_q.cmd.rd};
                    end
                    SQ_RSTART: begin
                        seq_d.st   = SQ_ADDR2;
                        seq_d.bitn = 4'd0;
                        seq_d.sh   = {seq_q.cmd.dev, 1'b1};
                    end
                    SQ_STOP: begin
                        seq_d.st = SQ_IDLE;
                        done     = 1'b1;
                    end
                    default: begin
                        if (seq_q.bitn != 4'd8) begin
                            seq_d.bitn = seq_q.bitn + 4'd1;
                            if (!receiving) seq_d.sh = {seq_q.sh[6:0], 1'b0};
                        end else begin
                            seq_d.bitn = 4'd0;
                            case (seq_q.st)
                                SQ_ADDR1: begin
                                    seq_d.st = (seq_q.nack || seq_q.cmd.quick) ? SQ_STOP : SQ_INDEX;
                                    seq_d.sh = seq_q.cmd.index;
                                end
                                SQ_INDEX: begin
                                    if (seq_q.nack)        seq_d.st = SQ_STOP;
                                    else if (seq_q.cmd.rd) seq_d.st = SQ_RSTART;
                                    else                   seq_d.st = SQ_WDATA;
                                    seq_d.sh = seq_q.cmd.wdata;
                                end
                                SQ_ADDR2: seq_d.st = seq_q.nack ? SQ_STOP : SQ_RDATA;
                                default:  seq_d.st = SQ_STOP;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= SQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        case (seq_q.st)
            SQ_START, SQ_RSTART: begin
                scl_low = (seq_q.qtr == 2'd0) || (seq_q.qtr == 2'd3);
                sda_low = seq_q.qtr[1];
            end
            SQ_STOP: begin
                scl_low = (seq_q.qtr == 2'd0);
                sda_low = !seq_q.qtr[1];
            end
            SQ_IDLE: begin
                scl_low = 1'b0;
                sda_low = 1'b0;
            end
            default: begin
                scl_low = (seq_q.qtr == 2'd0) || (seq_q.qtr == 2'd3);
                sda_low = (seq_q.bitn != 4'd8) && !receiving && !seq_q.sh[7];
            end
        endcase
    end

    assign nack     = seq_q.nack;
    assign rx_byte  = seq_q.sh;
    assign rx_valid = done && !seq_q.nack && seq_q.cmd.rd && !seq_q.cmd.quick;

    // R9: data line holds while the clock line is released inside a byte
    a_r9_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low && $past(!scl_low) && in_byte && $past(in_byte)) |-> $stable(sda_low));

    // R6: a refused byte is followed directly by the stop condition
    a_r6_nack_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_byte && tick && seq_q.qtr == 2'd3 && seq_q.bitn == 4'd8 && seq_q.nack)
        |=> (seq_q.st == SQ_STOP));

endmodule

// File: rtl/twb_master.sv
module twb_master
    import twb_pkg::*;
#(
    parameter int QTR_DIV = 125
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_wstrb,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        sda_in
);
    typedef struct packed {
        logic [7:0] data;
        logic [7:0] index;
        logic [7:0] tgt;
        logic       quick;
        logic       rdv;
        logic       err;
        logic       busy;
    } regs_t;

    regs_t    regs_d, regs_q;
    logic     go;
    twb_cmd_t cmd;
    logic     tick;
    logic     seq_done;
    logic     seq_nack;
    logic     seq_rx_valid;
    logic [7:0] seq_rx;
    logic     unused_wbits;

    assign unused_wbits = ^reg_wdata[31:25];

    always_comb begin
        regs_d = regs_q;
        go     = 1'b0;
        if (reg_we) begin
            if (reg_wstrb[BYTE_DATA])  regs_d.data  = reg_wdata[7:0];
            if (reg_wstrb[BYTE_INDEX]) regs_d.index = reg_wdata[15:8];
            if (reg_wstrb[BYTE_CTL])   regs_d.quick = reg_wdata[24];
            if (reg_wstrb[BYTE_TGT] && !regs_q.busy) begin
                regs_d.tgt  = reg_wdata[23:16];
                regs_d.busy = 1'b1;
                regs_d.rdv  = 1'b0;
                regs_d.err  = 1'b0;
                go          = 1'b1;
            end
        end
        cmd = '{quick: regs_d.quick, rd: regs_d.tgt[0], dev: regs_d.tgt[7:1],
                index: regs_d.index, wdata: regs_d.data};
        if (seq_done) begin
            regs_d.busy = 1'b0;
            regs_d.err  = seq_nack;
            if (seq_rx_valid) begin
                regs_d.rdv  = 1'b1;
                regs_d.data = seq_rx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    twb_clkdiv #(.QTR_DIV(QTR_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (go),
        .tick    (tick)
    );

    twb_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .go       (go),
        .cmd      (cmd),
        .sda_in   (sda_in),
        .scl_low  (scl_oe),
        .sda_low  (sda_oe),
        .done     (seq_done),
        .nack     (seq_nack),
        .rx_valid (seq_rx_valid),
        .rx_byte  (seq_rx)
    );

    assign reg_rdata = {4'b0000, regs_q.busy, regs_q.err, regs_q.rdv, regs_q.quick,
                        regs_q.tgt, regs_q.index, regs_q.data};

    // R7: a target write during a transfer leaves the stored target alone
    a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wstrb[BYTE_TGT] && regs_q.busy) |=> $stable(regs_q.tgt));

    // R8: a fresh transaction starts with clean flags
    a_r8_flags_clear_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q.busy) |-> (!regs_q.rdv && !regs_q.err));

    // R4: valid read data never coexists with an error
    a_r4_rdv_without_err: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.rdv |-> !regs_q.err);

    // R9: both lines are released whenever no transfer runs
    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.busy |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/twb_master_bench.sv
module twb_master_bench;
    localparam int QTR = 4;
    localparam logic [7:0] TX = 8'hA5;
    localparam int EV_S = 'h100;
    localparam int EV_P = 'h200;
    localparam int K0 = 'h400;
    localparam int K1 = 'h401;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        reg_we = 1'b0;
    logic [3:0]  reg_wstrb = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    wire  [31:0] reg_rdata;
    wire         scl_oe;
    wire         sda_oe;
    logic        slv_drive = 1'b0;
    wire         sda_line = !(sda_oe || slv_drive);
    wire         scl_line = !scl_oe;

    twb_master #(.QTR_DIV(QTR)) u_twb_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wstrb (reg_wstrb),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .sda_in    (sda_line)
    );

    int vectors = 0;
    int miscompares = 0;
    int log_q[$];
    int exp_q[$];
    int mstate = 0;
    int stop_wait = 0;
    int cyc = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural target and bus monitor
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    logic [7:0] sh = 8'h0;
    int cnt = 0;
    logic first = 1'b0, addressed = 1'b0, rdm = 1'b0, txa = 1'b0, txdone = 1'b0;
    int hi_cnt = 0;
    logic measuring = 1'b0;

    always @(posedge clk) begin
        logic scl_s, sda_s;
        #5;
        cyc++;
        if (rst_n) begin
            scl_s = scl_line;
            sda_s = sda_line;
            case (mstate)
                0: begin
                    check("R2 busy low while idle", {31'b0, reg_rdata[27]}, 32'd0);
                    check("R9 lines released while idle", {30'b0, scl_oe, sda_oe}, 32'd0);
                end
                1: check("R2 busy high during transfer", {31'b0, reg_rdata[27]}, 32'd1);
                default: begin
                    if (!reg_rdata[27]) mstate = 0;
                    else begin
                        stop_wait++;
                        if (stop_wait > 2 * QTR) begin
                            check("R2 busy clears after stop", 32'd1, 32'd0);
                            mstate = 0;
                        end
                    end
                end
            endcase
            if (scl_s && !prev_scl && mstate != 0) begin
                measuring = 1'b1;
                hi_cnt = 1;
            end else if (scl_s && measuring) begin
                hi_cnt++;
            end else if (!scl_s && prev_scl && measuring) begin
                check("R11 SCL high length", hi_cnt, 2 * QTR);
                measuring = 1'b0;
            end
            if (scl_s && prev_scl && prev_sda && !sda_s) begin
                log_q.push_back(EV_S);
                cnt = 0; first = 1'b1; txa = 1'b0; txdone = 1'b0; slv_drive = 1'b0;
            end else if (scl_s && prev_scl && !prev_sda && sda_s) begin
                log_q.push_back(EV_P);
                cnt = 0; first = 1'b0; addressed = 1'b0; txa = 1'b0; txdone = 1'b0;
                slv_drive = 1'b0; measuring = 1'b0;
                if (mstate == 1) begin mstate = 2; stop_wait = 0; end
            end else if (scl_s && !prev_scl) begin
                cnt++;
                if (cnt <= 8) sh = {sh[6:0], sda_s};
                else if (cnt == 9) log_q.push_back(K0 | int'(sda_s));
            end else if (!scl_s && prev_scl) begin
                if (cnt == 8) begin
                    log_q.push_back(int'(sh));
                    if (first) begin
                        first = 1'b0;
                        addressed = (sh[7:1] == 7'h50);
                        rdm = sh[0];
                        slv_drive = addressed;
                    end else if (txa) slv_drive = 1'b0;
                    else slv_drive = addressed;
                end else if (cnt == 9) begin
                    cnt = 0;
                    if (txa) begin
                        txa = 1'b0; txdone = 1'b1; slv_drive = 1'b0;
                    end else if (addressed && rdm && !txdone) begin
                        txa = 1'b1; slv_drive = !TX[7];
                    end else slv_drive = 1'b0;
                end else if (txa && cnt >= 1 && cnt <= 7) begin
                    slv_drive = !TX[7-cnt];
                end
            end
            prev_scl = scl_s;
            prev_sda = sda_line;
        end
        if (cyc > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wr(logic [3:0] strb, logic [31:0] word);
        @(negedge clk);
        reg_we = 1'b1; reg_wstrb = strb; reg_wdata = word;
        @(negedge clk);
        reg_we = 1'b0; reg_wstrb = 4'h0;
    endtask

    task automatic launch(logic [3:0] strb, logic [31:0] word);
        log_q.delete();
        @(negedge clk);
        reg_we = 1'b1; reg_wstrb = strb; reg_wdata = word;
        if (mstate == 0) mstate = 1;
        @(negedge clk);
        reg_we = 1'b0; reg_wstrb = 4'h0;
    endtask

    task automatic wait_idle(string tag);
        int n = 0;
        while ((mstate != 0 || reg_rdata[27]) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) check({tag, " transfer finishes"}, 32'd1, 32'd0);
    endtask

    task automatic cmp_log(string tag);
        check({tag, " event count"}, log_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < log_q.size(); i++) begin
            check($sformatf("%s event %0d", tag, i), log_q[i], exp_q[i]);
        end
    endtask

    task automatic read_check(string tag, logic [31:0] exp);
        @(negedge clk);
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset word", reg_rdata, 32'h0);
        check("R9 reset lines released", {30'b0, scl_oe, sda_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 readback, status bits read-only
        wr(4'h3, 32'h0000_5A3C);
        read_check("R1 data and index readback", 32'h0000_5A3C);
        wr(4'h8, 32'hFF00_0000);
        read_check("R1 control byte writable bit only", 32'h0100_5A3C);
        wr(4'h8, 32'h0000_0000);

        // R3 byte write with all bytes in one word (R10)
        launch(4'hF, 32'h00A0_1234);
        check("R2 busy right after launch", {31'b0, reg_rdata[27]}, 32'd1);
        wait_idle("R3");
        exp_q = '{EV_S, 'hA0, K0, 'h12, K0, 'h34, K0, EV_P};
        cmp_log("R3 byte write");
        read_check("R3 status after write", 32'h00A0_1234);

        // R4 byte read
        wr(4'h3, 32'h0000_4400);
        launch(4'h4, 32'h00A1_0000);
        wait_idle("R4");
        exp_q = '{EV_S, 'hA0, K0, 'h44, K0, EV_S, 'hA1, K0, 'hA5, K1, EV_P};
        cmp_log("R4 byte read");
        read_check("R4 received byte and valid flag", 32'h02A1_44A5);

        // R6 missing ack, R8 valid flag cleared at launch
        launch(4'h4, 32'h0066_0000);
        check("R8 valid flag cleared at launch", {31'b0, reg_rdata[25]}, 32'd0);
        wait_idle("R6");
        exp_q = '{EV_S, 'h66, K1, EV_P};
        cmp_log("R6 refused write address");
        read_check("R6 error status after refusal", 32'h0466_44A5);

        launch(4'h4, 32'h0067_0000);
        wait_idle("R6 read");
        exp_q = '{EV_S, 'h66, K1, EV_P};
        cmp_log("R6 refused read address");
        read_check("R6 read refusal keeps data", 32'h0467_44A5);

        // R8 error cleared at launch
        launch(4'h4, 32'h00A0_0000);
        check("R8 error cleared at launch", {31'b0, reg_rdata[26]}, 32'd0);
        wait_idle("R8");
        exp_q = '{EV_S, 'hA0, K0, 'h44, K0, 'hA5, K0, EV_P};
        cmp_log("R8 write after error");

        // R5 quick command both directions
        wr(4'h8, 32'h0100_0000);
        launch(4'h4, 32'h00A0_0000);
        wait_idle("R5");
        exp_q = '{EV_S, 'hA0, K0, EV_P};
        cmp_log("R5 quick write");
        read_check("R5 quick write status", 32'h01A0_44A5);
        launch(4'h4, 32'h00A1_0000);
        wait_idle("R5 read");
        exp_q = '{EV_S, 'hA1, K0, EV_P};
        cmp_log("R5 quick read");
        read_check("R5 quick read no valid flag", 32'h01A1_44A5);

        // R7 target write while busy
        wr(4'h8, 32'h0000_0000);
        launch(4'h4, 32'h00A0_0000);
        repeat (30) @(negedge clk);
        wr(4'h4, 32'h00A2_0000);
        wait_idle("R7");
        repeat (4 * QTR) @(negedge clk);
        exp_q = '{EV_S, 'hA0, K0, 'h44, K0, 'hA5, K0, EV_P};
        cmp_log("R7 single transaction");
        read_check("R7 target byte unchanged", 32'h00A0_44A5);

        // R10 same-word launch picks new protocol, index and data
        launch(4'hF, 32'h01A1_7788);
        wait_idle("R10 quick");
        exp_q = '{EV_S, 'hA1, K0, EV_P};
        cmp_log("R10 quick from one word");
        read_check("R10 quick word readback", 32'h01A1_7788);
        launch(4'hF, 32'h00A0_9CE1);
        wait_idle("R10 write");
        exp_q = '{EV_S, 'hA0, K0, 'h9C, K0, 'hE1, K0, EV_P};
        cmp_log("R10 write from one word");

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule